// File: doc/BRIEF.md
# Memory-Access Instruction Decoder with Width Gating

This block looks at one 32-bit instruction word and says whether it is a memory read, a memory write, or something else. For reads and writes it reports the access width, whether the value is unsigned, and whether the fetched value must be extended to fill the register. It also extracts the register indices and the sign-extended address offset.

A mode input selects a 32-bit or a 64-bit register width while the block runs. In 32-bit mode, the doubleword accesses and the zero-extending word read are flagged as illegal. The block is purely combinational, so the execution pipeline can place it in a decode stage and register its outputs wherever that stage needs them.

Top module: `ldst_decoder`

## Requirements
- R1: Bits 6:0 equal to 0000011 raise `is_load_o`. Bits 6:0 equal to 0100011 raise `is_store_o`. Any other value raises `not_ldst_o`. Exactly one of the three is high at any time.
- R2: Reads with bits 14:12 of 000, 001 or 010 give `size_o` 0, 1 or 2 with `unsigned_o`=0. Values 100 and 101 give `size_o` 0 and 1 with `unsigned_o`=1. All five are legal in both modes.
- R3: A read with bits 14:12 = 011 is a doubleword (`size_o`=3, signed). It is legal when `rv64_i`=1 and sets `illegal_o` when `rv64_i`=0.
- R4: A read with bits 14:12 = 110 is an unsigned word (`size_o`=2, `unsigned_o`=1). It is legal when `rv64_i`=1 and sets `illegal_o` when `rv64_i`=0.
- R5: A read with bits 14:12 = 111 sets `illegal_o` in both modes.
- R6: Writes with bits 14:12 of 000, 001 or 010 are legal with `size_o` 0, 1 or 2. The value 011 gives `size_o`=3 and is legal only when `rv64_i`=1.
- R7: A write with bits 14:12 = 100, 101, 110 or 111 sets `illegal_o` in both modes.
- R8: `widen_o` is 1 for legal byte and halfword reads and for the unsigned word read. For the signed word read it equals `rv64_i`. For doubleword reads and for all writes it is 0.
- R9: For reads, `offset_o` is bits 31:20 sign-extended to 64 bits, in either mode.
- R10: For writes, `offset_o` is {bits 31:25, bits 11:7} sign-extended to 64 bits, in either mode.
- R11: Reads output `rd_o` = bits 11:7, `rs1_o` = bits 19:15 and `rs2_o` = 0. Writes output `rd_o` = 0, `rs1_o` = bits 19:15 and `rs2_o` = bits 24:20.
- R12: When `not_ldst_o`=1, every other output is 0, including `illegal_o`.
- R13: When `illegal_o`=1, `size_o`, `unsigned_o` and `widen_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rv64_i | input | 1 | 1 selects 64-bit register width, 0 selects 32-bit |
| is_load_o | output | 1 | Memory read opcode |
| is_store_o | output | 1 | Memory write opcode |
| not_ldst_o | output | 1 | Neither read nor write |
| illegal_o | output | 1 | Width code not allowed in the current mode |
| size_o | output | 2 | 0 byte, 1 half, 2 word, 3 double |
| unsigned_o | output | 1 | Zero-extend the read value |
| widen_o | output | 1 | Read value is narrower than the register |
| rd_o | output | 5 | Destination register |
| rs1_o | output | 5 | Base register |
| rs2_o | output | 5 | Data source register |
| offset_o | output | 64 | Sign-extended offset |

## Verification
Every width code of both major opcodes is applied in both modes. This separates the codes that are always legal, the ones that depend on the mode, and the ones that are never legal. It also shows the signed word read switching its extension flag with the mode. Offsets are tried at the largest positive value, the most negative value, and with bits set on both sides of the split write field, so a wrong sign bit or a swapped field fails. Register fields use values that overlap the immediate bits, so a field leaking across shows up. Non-memory opcodes, including one whose low two bits differ only slightly from a memory opcode, must leave every other output quiet.

// File: rtl/ldst_decoder.sv
module ldst_decoder #(
  parameter int OFF_W = 64,
  parameter int REG_W = 5
) (
  input  logic [31:0]      instr_i,
  input  logic             rv64_i,
  output logic             is_load_o,
  output logic             is_store_o,
  output logic             not_ldst_o,
  output logic             illegal_o,
  output logic [1:0]       size_o,
  output logic             unsigned_o,
  output logic             widen_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rs1_o,
  output logic [REG_W-1:0] rs2_o,
  output logic [OFF_W-1:0] offset_o
);
  localparam logic [6:0] OP_RD = 7'b0000011;
  localparam logic [6:0] OP_WR = 7'b0100011;

  logic [2:0]  fn;
  logic        ok, uns, wid;
  logic [1:0]  sz;
  logic [11:0] imm;

  assign fn         = instr_i[14:12];
  assign is_load_o  = instr_i[6:0] == OP_RD;
  assign is_store_o = instr_i[6:0] == OP_WR;
  assign not_ldst_o = !(is_load_o || is_store_o);

  always_comb begin
    ok  = 1'b0;
    sz  = 2'd0;
    uns = 1'b0;
    wid = 1'b0;
    if (is_load_o) begin
      case (fn)
        3'b000: begin ok = 1'b1; sz = 2'd0; wid = 1'b1; end
        3'b001: begin ok = 1'b1; sz = 2'd1; wid = 1'b1; end
        3'b010: begin ok = 1'b1; sz = 2'd2; wid = rv64_i; end
        3'b011: begin ok = rv64_i; sz = 2'd3; end
        3'b100: begin ok = 1'b1; sz = 2'd0; uns = 1'b1; wid = 1'b1; end
        3'b101: begin ok = 1'b1; sz = 2'd1; uns = 1'b1; wid = 1'b1; end
        3'b110: begin ok = rv64_i; sz = 2'd2; uns = 1'b1; wid = 1'b1; end
        default: ok = 1'b0;
      endcase
    end else if (is_store_o) begin
      case (fn)
        3'b000: begin ok = 1'b1; sz = 2'd0; end
        3'b001: begin ok = 1'b1; sz = 2'd1; end
        3'b010: begin ok = 1'b1; sz = 2'd2; end
        3'b011: begin ok = rv64_i; sz = 2'd3; end
        default: ok = 1'b0;
      endcase
    end
  end

  assign illegal_o  = !not_ldst_o && !ok;
  assign size_o     = ok ? sz  : 2'd0;
  assign unsigned_o = ok && uns;
  assign widen_o    = ok && wid;

  assign imm = is_load_o  ? instr_i[31:20] :
               is_store_o ? {instr_i[31:25], instr_i[11:7]} : 12'd0;
  assign offset_o = {{(OFF_W-12){imm[11]}}, imm};

  assign rd_o  = is_load_o  ? instr_i[11:7]  : '0;
  assign rs1_o = not_ldst_o ? '0 : instr_i[19:15];
  assign rs2_o = is_store_o ? instr_i[24:20] : '0;
endmodule

// File: rtl/ldst_decoder_chk.sv
module ldst_decoder_chk #(
  parameter int OFF_W = 64,
  parameter int REG_W = 5
) (
  input logic [31:0]      instr_i,
  input logic             rv64_i,
  input logic             is_load_o,
  input logic             is_store_o,
  input logic             not_ldst_o,
  input logic             illegal_o,
  input logic [1:0]       size_o,
  input logic             unsigned_o,
  input logic             widen_o,
  input logic [REG_W-1:0] rd_o,
  input logic [REG_W-1:0] rs1_o,
  input logic [REG_W-1:0] rs2_o,
  input logic [OFF_W-1:0] offset_o
);
  always_comb begin
    if (!$isunknown({instr_i, rv64_i})) begin
      a_r1_one_class: assert ($countones({is_load_o, is_store_o, not_ldst_o}) == 1);
      a_r12_quiet: assert (!not_ldst_o ||
        (!illegal_o && size_o == 2'd0 && !unsigned_o && !widen_o &&
         rd_o == '0 && rs1_o == '0 && rs2_o == '0 && offset_o == '0));
      a_r13_illegal_zero: assert (!illegal_o || (size_o == 2'd0 && !unsigned_o && !widen_o));
      a_r3_no_double_rv32: assert (rv64_i || illegal_o || size_o != 2'd3);
      a_r4_unsigned_word: assert (!(unsigned_o && size_o == 2'd2) || (rv64_i && is_load_o));
      a_r8_store_no_widen: assert (!is_store_o || !widen_o);
      a_r11_store_no_rd: assert (!is_store_o || rd_o == '0);
    end
  end
endmodule

bind ldst_decoder ldst_decoder_chk #(.OFF_W(OFF_W), .REG_W(REG_W)) i_chk (.*);

// File: tb/test_ldst_decoder.sv
module test_ldst_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr;
  logic        rv64;
  logic        is_ld, is_st, not_ls, ill, uns, wid;
  logic [1:0]  size;
  logic [4:0]  rd, rs1, rs2;
  logic [63:0] off;

  int total = 0, bad = 0;
  bit done = 0;

  ldst_decoder i_ldst_decoder (
    .instr_i(instr), .rv64_i(rv64), .is_load_o(is_ld), .is_store_o(is_st),
    .not_ldst_o(not_ls), .illegal_o(ill), .size_o(size), .unsigned_o(uns),
    .widen_o(wid), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .offset_o(off)
  );

  function automatic logic [31:0] mk_rd(logic [11:0] im, logic [4:0] b, logic [2:0] f, logic [4:0] d);
    return {im, b, f, d, 7'b0000011};
  endfunction
  function automatic logic [31:0] mk_wr(logic [11:0] im, logic [4:0] b, logic [2:0] f, logic [4:0] s);
    return {im[11:5], s, b, f, im[4:0], 7'b0100011};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s instr=%h rv64=%0d got=%h exp=%h", req, instr, rv64, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic m);
    @(negedge clk);
    instr = w;
    rv64  = m;
    #2;
  endtask

  task automatic t_idle;
    apply(32'h0, 1'b0);
    check("R1 idle class", {is_ld, is_st, not_ls}, 3'b001);
    check("R12 idle quiet", {ill, size, uns, wid, rd, rs1, rs2}, '0);
    check("R12 idle offset", off, 64'd0);
  endtask

  task automatic t_load_widths;
    logic [2:0] fs [5] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5};
    logic [1:0] sz [5] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1};
    logic       us [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 5; k++) begin
        apply(mk_rd(12'h010, 5'd2, fs[k], 5'd7), m[0]);
        check("R1 load class", {is_ld, is_st, not_ls}, 3'b100);
        check("R2 load legal/size/unsigned", {ill, size, uns}, {1'b0, sz[k], us[k]});
        check("R8 load widen", wid, (fs[k] == 3'd2) ? m[0] : 1'b1);
      end
  endtask

  task automatic t_mode_gated;
    for (int m = 0; m < 2; m++) begin
      apply(mk_rd(12'h0, 5'd1, 3'b011, 5'd3), m[0]);
      check("R3 double load", {ill, size, uns, wid}, m ? 5'b0_11_0_0 : 5'b1_00_0_0);
      apply(mk_rd(12'h0, 5'd1, 3'b110, 5'd3), m[0]);
      check("R4 unsigned word load", {ill, size, uns, wid}, m ? 5'b0_10_1_1 : 5'b1_00_0_0);
      apply(mk_wr(12'h0, 5'd1, 3'b011, 5'd3), m[0]);
      check("R6 double store", {ill, size, uns, wid}, m ? 5'b0_11_0_0 : 5'b1_00_0_0);
      for (int f = 0; f < 3; f++) begin
        apply(mk_wr(12'h0, 5'd1, f[2:0], 5'd3), m[0]);
        check("R6 store size", {is_st, ill, size, uns, wid}, {1'b1, 1'b0, f[1:0], 2'b00});
      end
    end
  endtask

  task automatic t_never_legal;
    for (int m = 0; m < 2; m++) begin
      apply(mk_rd(12'h0, 5'd4, 3'b111, 5'd5), m[0]);
      check("R5 load 111 illegal", ill, 1'b1);
      check("R13 zeroed fields", {size, uns, wid}, 4'b0);
      for (int f = 4; f < 8; f++) begin
        apply(mk_wr(12'h0, 5'd4, f[2:0], 5'd5), m[0]);
        check("R7 store 1xx illegal", {is_st, ill}, 2'b11);
        check("R13 zeroed fields", {size, uns, wid}, 4'b0);
      end
    end
  endtask

  task automatic t_offsets;
    apply(mk_rd(12'h7FF, 5'd1, 3'b000, 5'd1), 1'b0);
    check("R9 load max offset", off, 64'h0000_0000_0000_07FF);
    apply(mk_rd(12'h800, 5'd1, 3'b000, 5'd1), 1'b1);
    check("R9 load min offset", off, 64'hFFFF_FFFF_FFFF_F800);
    apply({7'h7F, 5'd2, 5'd1, 3'b010, 5'h1F, 7'b0100011}, 1'b0);
    check("R10 store offset -1", off, 64'hFFFF_FFFF_FFFF_FFFF);
    apply({7'h40, 5'd2, 5'd1, 3'b010, 5'h00, 7'b0100011}, 1'b1);
    check("R10 store min offset", off, 64'hFFFF_FFFF_FFFF_F800);
    apply({7'h01, 5'd2, 5'd1, 3'b000, 5'h03, 7'b0100011}, 1'b0);
    check("R10 store split offset", off, 64'h0000_0000_0000_0023);
  endtask

  task automatic t_regs;
    apply(mk_rd(12'h5A3, 5'd17, 3'b010, 5'd31), 1'b1);
    check("R11 load regs", {rd, rs1, rs2}, {5'd31, 5'd17, 5'd0});
    apply(mk_wr(12'h015, 5'd3, 3'b001, 5'd9), 1'b0);
    check("R11 store regs", {rd, rs1, rs2}, {5'd0, 5'd3, 5'd9});
    check("R8 store widen", wid, 1'b0);
  endtask

  task automatic t_other;
    logic [6:0] ops [3] = '{7'b0010011, 7'b0000111, 7'b0000010};
    for (int k = 0; k < 3; k++) begin
      apply({12'hFFF, 5'd9, 3'b011, 5'd9, ops[k]}, 1'b0);
      check("R1 other class", {is_ld, is_st, not_ls}, 3'b001);
      check("R12 other quiet", {ill, size, uns, wid, rd, rs1, rs2}, '0);
      check("R12 other offset", off, 64'd0);
    end
  endtask

  initial begin
    instr = '0;
    rv64  = 1'b0;
    t_idle();
    t_load_widths();
    t_mode_gated();
    t_never_legal();
    t_offsets();
    t_regs();
    t_other();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule